// File: doc/BRIEF.md
# Write Burst Protocol Monitor

This block is a passive observer for the address and data halves of a memory-mapped write bus. It drives nothing onto the bus. It watches both halves and reports rule breaks. Each accepted write address carries a burst length, stored as beats minus one, and a beat size. The monitor keeps each accepted length in a small ordered queue. It then counts the data beats of each burst against the length at the head of that queue. It checks that the last-beat marker is high on the final beat and on no other beat.

On the data half it also enforces the valid/ready rules. A valid that has been raised must not be dropped before ready is seen. While the receiver stalls, the data, the strobes and the last-beat marker must hold their values. The last-beat marker counts as part of the payload. A source that raises it late inside a stalled beat therefore breaks the stability rule. On the address half the monitor flags any beat size wider than the data bus, and any address that arrives while the length queue is full.

Each rule has two outputs. A one-cycle pulse marks the cycle in which the break was seen. A sticky flag stays set until reset. The monitor can sit on any write port in a simulation or emulation build without changing the traffic.

Top module: `wr_burst_monitor`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), every bit of errPulse and errSticky is 0.
- R2: If a cycle has dataValid high and dataReady low, and the next cycle has dataValid low, errPulse bit 0 is high for one cycle after the edge that samples the drop.
- R3: If a cycle has dataValid high and dataReady low, and the next cycle has dataValid high with dataBus, dataStrb or dataLast different, errPulse bit 1 pulses. A last-beat marker raised late inside a stalled beat counts as such a change.
- R4: Cycles with dataValid low carry no beat and no payload check. This holds even when dataReady is high and dataLast, dataBus or dataStrb hold arbitrary values. Such cycles raise no pulse and do not advance the beat count.
- R5: A burst length of 0 means one beat. If that beat is accepted with dataLast low, errPulse bit 3 (missing last) pulses.
- R6: An accepted beat with dataLast high whose index within the burst is below the stored length raises errPulse bit 2 (early last). The burst is then closed.
- R7: A burst of length L whose beats 0..L-1 have dataLast low and whose beat L has dataLast high raises no pulse. Stalls in the middle of the burst do not change this, provided the payload holds.
- R8: An accepted address whose size field s gives 2^s bytes, more than DATA_W/8, raises errPulse bit 4. For the default 32-bit bus this means s greater than 2. The length is still queued.
- R9: The length queue holds Q_DEPTH entries (default 4). An address accepted while the queue is full, in a cycle that frees no entry, raises errPulse bit 5, and its length is dropped.
- R10: Beats accepted while the queue is empty are counted. They are checked against the next queued length in the first cycle it is at the head, with the same early or missing last result as live beats. Only one such waiting burst is tracked, and beats that arrive after its last beat, before its address, are not counted.
- R11: Each errSticky bit is set in the same cycle as its pulse and stays set until reset. Each pulse lasts exactly one cycle per violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addrValid | input | 1 | Write address valid |
| addrReady | input | 1 | Write address ready |
| addrLen | input | LEN_W | Burst length, beats minus one |
| addrSize | input | 3 | Beat size, log2 of bytes |
| dataValid | input | 1 | Write data valid |
| dataReady | input | 1 | Write data ready |
| dataBus | input | DATA_W | Write data |
| dataStrb | input | DATA_W/8 | Write byte strobes |
| dataLast | input | 1 | Last beat of burst marker |
| errPulse | output | RULE_N | One-cycle violation pulses: 0 drop, 1 payload, 2 early last, 3 missing last, 4 size, 5 overflow |
| errSticky | output | RULE_N | Sticky violation flags, same bit order |

## Verification
Most internal faults show up in the early-last or missing-last pulses within one beat of the burst that the fault touches. Such faults include a beat counter that drifts, a queue pointer that skips, or a lost deferred-burst flag. A wrong head entry, for example, flags the first beat whose index crosses the wrong length. A stale stall register shows up as a false or missing drop or payload pulse in the cycle right after the stall. An orphan burst that is resolved wrongly shows up in the first cycle its address reaches the head of the queue.

// File: rtl/wrmon_pkg.sv
package wrmon_pkg;
  localparam int RULE_N = 6;
  localparam int RULE_DROP = 0;
  localparam int RULE_PAYLOAD = 1;
  localparam int RULE_EARLY = 2;
  localparam int RULE_MISSING = 3;
  localparam int RULE_SIZE = 4;
  localparam int RULE_OVERFLOW = 5;

  typedef struct packed {
    logic push;
    logic pop;
    logic cntInc;
    logic cntClr;
    logic pendSet;
    logic pendClr;
    logic unchkSet;
    logic unchkClr;
  } wrmonStrobe_t;
endpackage

// File: rtl/wrmon_datapath.sv
module wrmon_datapath
  import wrmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W = 8,
  parameter int Q_DEPTH = 4,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrmonStrobe_t      ctl,
  input  logic [LEN_W-1:0]  addrLen,
  input  logic              dataValid,
  input  logic              dataReady,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [STRB_W-1:0] dataStrb,
  input  logic              dataLast,
  output logic              headValid,
  output logic [LEN_W-1:0]  headLen,
  output logic              qFull,
  output logic [LEN_W:0]    beatCnt,
  output logic              pend,
  output logic              unchk,
  output logic              prevStall,
  output logic              payloadMoved
);
  localparam int PTR_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(Q_DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(Q_DEPTH);

  logic [LEN_W-1:0] lenMem [Q_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] qCount;
  logic [DATA_W-1:0] prevData;
  logic [STRB_W-1:0] prevStrb;
  logic prevLast;
  logic [LEN_W:0] cntBase;

  assign headValid = (qCount != '0);
  assign qFull = (qCount == CNT_FULL);
  assign headLen = lenMem[rdPtr];
  assign payloadMoved = (dataBus != prevData) || (dataStrb != prevStrb) || (dataLast != prevLast);
  assign cntBase = ctl.cntClr ? '0 : beatCnt;

  always_ff @(posedge clk) begin
    if (ctl.push) lenMem[wrPtr] <= addrLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      qCount <= '0;
    end else begin
      if (ctl.push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (ctl.pop) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (ctl.push && !ctl.pop) qCount <= qCount + 1'b1;
      else if (ctl.pop && !ctl.push) qCount <= qCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      pend <= 1'b0;
      unchk <= 1'b0;
    end else begin
      beatCnt <= (ctl.cntInc && (cntBase != '1)) ? cntBase + 1'b1 : cntBase;
      if (ctl.pendSet) pend <= 1'b1;
      else if (ctl.pendClr) pend <= 1'b0;
      if (ctl.unchkSet) unchk <= 1'b1;
      else if (ctl.unchkClr) unchk <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStall <= 1'b0;
      prevData <= '0;
      prevStrb <= '0;
      prevLast <= 1'b0;
    end else begin
      prevStall <= dataValid && !dataReady;
      prevData <= dataBus;
      prevStrb <= dataStrb;
      prevLast <= dataLast;
    end
  end
endmodule

// File: rtl/wrmon_control.sv
module wrmon_control
  import wrmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              addrReady,
  input  logic [2:0]        addrSize,
  input  logic              dataValid,
  input  logic              dataReady,
  input  logic              dataLast,
  input  logic              headValid,
  input  logic [LEN_W-1:0]  headLen,
  input  logic              qFull,
  input  logic [LEN_W:0]    beatCnt,
  input  logic              pend,
  input  logic              unchk,
  input  logic              prevStall,
  input  logic              payloadMoved,
  output wrmonStrobe_t      ctl,
  output logic [RULE_N-1:0] errPulse,
  output logic [RULE_N-1:0] errSticky
);
  localparam logic [2:0] SIZE_MAX = 3'($clog2(DATA_W / 8));

  logic addrFire, dataFire;
  logic [LEN_W:0] lenExt, lastIdx;
  logic [RULE_N-1:0] viol;

  assign addrFire = addrValid && addrReady;
  assign dataFire = dataValid && dataReady;
  assign lenExt = {1'b0, headLen};
  assign lastIdx = beatCnt - 1'b1;

  always_comb begin
    ctl = '0;
    viol = '0;
    if (prevStall && !dataValid) viol[RULE_DROP] = 1'b1;
    if (prevStall && dataValid && payloadMoved) viol[RULE_PAYLOAD] = 1'b1;
    if (addrFire && (addrSize > SIZE_MAX)) viol[RULE_SIZE] = 1'b1;

    if (headValid && pend) begin
      // a burst that finished before its address: judge it now
      ctl.pop = 1'b1;
      ctl.cntClr = 1'b1;
      ctl.pendClr = 1'b1;
      ctl.unchkClr = 1'b1;
      if (lastIdx < lenExt) viol[RULE_EARLY] = 1'b1;
      if (lastIdx > lenExt) viol[RULE_MISSING] = 1'b1;
      if (dataFire) begin
        ctl.cntInc = 1'b1;
        if (dataLast) ctl.pendSet = 1'b1;
        else ctl.unchkSet = 1'b1;
      end
    end else if (headValid) begin
      if (unchk) begin
        ctl.unchkClr = 1'b1;
        if (beatCnt > lenExt) viol[RULE_MISSING] = 1'b1;
      end
      if (dataFire) begin
        if (dataLast && (beatCnt < lenExt)) viol[RULE_EARLY] = 1'b1;
        if (!dataLast && (beatCnt == lenExt)) viol[RULE_MISSING] = 1'b1;
        if (dataLast) begin
          ctl.pop = 1'b1;
          ctl.cntClr = 1'b1;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
    end else if (dataFire && !pend) begin
      ctl.cntInc = 1'b1;
      if (dataLast) ctl.pendSet = 1'b1;
      else ctl.unchkSet = 1'b1;
    end

    ctl.push = addrFire && (!qFull || ctl.pop);
    if (addrFire && qFull && !ctl.pop) viol[RULE_OVERFLOW] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse <= '0;
      errSticky <= '0;
    end else begin
      errPulse <= viol;
      errSticky <= errSticky | viol;
    end
  end
endmodule

// File: rtl/wr_burst_monitor.sv
module wr_burst_monitor
  import wrmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W = 8,
  parameter int Q_DEPTH = 4,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              addrReady,
  input  logic [LEN_W-1:0]  addrLen,
  input  logic [2:0]        addrSize,
  input  logic              dataValid,
  input  logic              dataReady,
  input  logic [DATA_W-1:0] dataBus,
  input  logic [STRB_W-1:0] dataStrb,
  input  logic              dataLast,
  output logic [RULE_N-1:0] errPulse,
  output logic [RULE_N-1:0] errSticky
);
  wrmonStrobe_t ctl;
  logic headValid, qFull, pend, unchk, prevStall, payloadMoved;
  logic [LEN_W-1:0] headLen;
  logic [LEN_W:0] beatCnt;

  wrmon_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W), .Q_DEPTH(Q_DEPTH)) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrLen(addrLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataBus(dataBus),
    .dataStrb(dataStrb), .dataLast(dataLast),
    .headValid(headValid), .headLen(headLen), .qFull(qFull), .beatCnt(beatCnt),
    .pend(pend), .unchk(unchk), .prevStall(prevStall), .payloadMoved(payloadMoved)
  );

  wrmon_control #(.DATA_W(DATA_W), .LEN_W(LEN_W)) ctlInst (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrReady(addrReady),
    .addrSize(addrSize), .dataValid(dataValid), .dataReady(dataReady),
    .dataLast(dataLast), .headValid(headValid), .headLen(headLen), .qFull(qFull),
    .beatCnt(beatCnt), .pend(pend), .unchk(unchk), .prevStall(prevStall),
    .payloadMoved(payloadMoved), .ctl(ctl), .errPulse(errPulse), .errSticky(errSticky)
  );
endmodule

// File: rtl/wr_burst_monitor_chk.sv
module wr_burst_monitor_chk
  import wrmon_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrValid,
  input logic              addrReady,
  input logic [2:0]        addrSize,
  input logic              dataValid,
  input logic              dataReady,
  input logic [DATA_W-1:0] dataBus,
  input logic [STRB_W-1:0] dataStrb,
  input logic              dataLast,
  input logic [RULE_N-1:0] errPulse,
  input logic [RULE_N-1:0] errSticky
);
  localparam logic [2:0] SIZE_MAX = 3'($clog2(DATA_W / 8));

  // R2
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(dataValid && !dataReady) && !dataValid) |=> errPulse[RULE_DROP]);

  // R3
  payload_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(dataValid && !dataReady) && dataValid &&
     ((dataBus != $past(dataBus)) || (dataStrb != $past(dataStrb)) || (dataLast != $past(dataLast))))
    |=> errPulse[RULE_PAYLOAD]);

  // R8
  size_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrReady && (addrSize > SIZE_MAX)) |=> errPulse[RULE_SIZE]);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((errSticky & $past(errSticky)) == $past(errSticky)));

  // R11
  pulse_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((errSticky & errPulse) == errPulse));
endmodule

bind wr_burst_monitor wr_burst_monitor_chk #(.DATA_W(DATA_W)) chkInst (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrReady(addrReady),
  .addrSize(addrSize), .dataValid(dataValid), .dataReady(dataReady),
  .dataBus(dataBus), .dataStrb(dataStrb), .dataLast(dataLast),
  .errPulse(errPulse), .errSticky(errSticky)
);

// File: tb/wr_burst_monitor_test.sv
module wr_burst_monitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrValid = 1'b0, addrReady = 1'b0;
  logic [7:0] addrLen = '0;
  logic [2:0] addrSize = '0;
  logic dataValid = 1'b0, dataReady = 1'b0, dataLast = 1'b0;
  logic [31:0] dataBus = '0;
  logic [3:0] dataStrb = '0;
  logic [5:0] errPulse, errSticky;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [5:0] expQ[$];
  string reqQ[$];

  always #2 clk = ~clk;

  wr_burst_monitor uut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrReady(addrReady),
    .addrLen(addrLen), .addrSize(addrSize), .dataValid(dataValid),
    .dataReady(dataReady), .dataBus(dataBus), .dataStrb(dataStrb),
    .dataLast(dataLast), .errPulse(errPulse), .errSticky(errSticky)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // driver: one bus cycle, expected pulse vector pushed to the scoreboard
  task automatic step(input logic aV, input logic [7:0] aLen, input logic [2:0] aSz,
                      input logic wV, input logic wR, input logic [31:0] d,
                      input logic wl, input logic [5:0] exp, input string req);
    addrValid = aV; addrReady = aV; addrLen = aLen; addrSize = aSz;
    dataValid = wV; dataReady = wR; dataBus = d; dataStrb = d[3:0]; dataLast = wl;
    expQ.push_back(exp);
    reqQ.push_back(req);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic [5:0] exp, input string req);
    step(1'b0, 8'd0, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0, exp, req);
  endtask

  // monitor: compares each registered pulse vector after its edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [5:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(r, errPulse, e);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check("R1 pulse", errPulse, 6'h00);
    check("R1 sticky", errSticky, 6'h00);

    // R7 legal three-beat burst with a held stall; R4 ready without valid
    step(1, 8'd2, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R7 addr");
    step(0, 8'd0, 3'd0, 1, 1, 32'hA, 0, 6'h00, "R7 beat0");
    step(0, 8'd0, 3'd0, 0, 1, 32'hDEAD, 1, 6'h00, "R4 ready no valid");
    step(0, 8'd0, 3'd0, 1, 0, 32'hB, 0, 6'h00, "R7 stall");
    step(0, 8'd0, 3'd0, 1, 1, 32'hB, 0, 6'h00, "R7 beat1");
    step(0, 8'd0, 3'd0, 1, 1, 32'hC, 1, 6'h00, "R7 beat2");

    // R5 single beat without last
    step(1, 8'd0, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R5 addr");
    step(0, 8'd0, 3'd0, 1, 1, 32'h1, 0, 6'h08, "R5 missing last");
    step(0, 8'd0, 3'd0, 1, 1, 32'h2, 1, 6'h00, "R5 close");

    // R6 early last
    step(1, 8'd2, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R6 addr");
    step(0, 8'd0, 3'd0, 1, 1, 32'h3, 1, 6'h04, "R6 early last");

    // R3 last raised late inside a stalled beat
    step(1, 8'd0, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R3 addr");
    step(0, 8'd0, 3'd0, 1, 0, 32'hD, 0, 6'h00, "R3 stall");
    step(0, 8'd0, 3'd0, 1, 1, 32'hD, 1, 6'h02, "R3 late last");

    // R2 valid dropped under stall
    step(0, 8'd0, 3'd0, 1, 0, 32'hE, 1, 6'h00, "R2 stall");
    idle(6'h01, "R2 drop");

    // R8 oversize beat
    step(1, 8'd0, 3'd3, 0, 0, 32'h0, 0, 6'h10, "R8 size");
    step(0, 8'd0, 3'd0, 1, 1, 32'h5, 1, 6'h00, "R8 drain");

    // R10 orphan burst that matches its later address
    step(0, 8'd0, 3'd0, 1, 1, 32'h6, 0, 6'h00, "R10 orphan0");
    step(0, 8'd0, 3'd0, 1, 1, 32'h7, 1, 6'h00, "R10 orphan1");
    step(1, 8'd1, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R10 addr");
    idle(6'h00, "R10 resolve ok");
    // R10 orphan burst shorter than its address
    step(0, 8'd0, 3'd0, 1, 1, 32'h8, 1, 6'h00, "R10 orphan short");
    step(1, 8'd3, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R10 addr short");
    idle(6'h04, "R10 resolve early");
    // R10 open orphan burst longer than its address
    step(0, 8'd0, 3'd0, 1, 1, 32'h9, 0, 6'h00, "R10 open0");
    step(0, 8'd0, 3'd0, 1, 1, 32'hA, 0, 6'h00, "R10 open1");
    step(1, 8'd0, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R10 addr long");
    idle(6'h08, "R10 resolve missing");
    step(0, 8'd0, 3'd0, 1, 1, 32'hB, 1, 6'h00, "R10 close");

    // R9 queue overflow
    for (int i = 0; i < 4; i++) step(1, 8'd0, 3'd2, 0, 0, 32'h0, 0, 6'h00, "R9 fill");
    step(1, 8'd0, 3'd2, 0, 0, 32'h0, 0, 6'h20, "R9 overflow");
    for (int i = 0; i < 4; i++) step(0, 8'd0, 3'd0, 1, 1, 32'h1, 1, 6'h00, "R9 drain");
    idle(6'h00, "R11 pulse ends");
    #1;

    check("R11 sticky all", errSticky, 6'h3F);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    check("R11 sticky cleared", errSticky, 6'h00);
    check("R1 pulse cleared", errPulse, 6'h00);
    rstN = 1'b1;

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule